// File: doc/BRIEF.md
# SPI Host Synchronisation Handshake Controller

This block is the host side of a 16-bit SPI link to a slave device that sits in a reset-wait state until the host sends it a fixed wake-up message. When software pulses a start request, the block clocks out eight half-words. The first two carry the ASCII text "CNYS". The other six are all ones. The block then waits for the slave to pull its active-low host interrupt line. After that it runs two readback frames and compares the words it receives with the two acknowledgement values the slave must return.

Each half-word travels in its own chip-select window, with at least two SPI clock periods between chip-select falling and the first SCLK edge. Chip-select then stays high for at least two SPI periods before the next frame. The same port can also push a single arbitrary half-word, which is useful for sending messages once the link is synchronised. The outcome is reported on three sticky flags: done, error and timeout.

Top module: `spi_sync_host`

## Requirements
- R1: Each half-word is sent in one window where chip-select `cs_no` is low, with exactly 16 rising SCLK edges in that window. SCLK stays low whenever chip-select is high.
- R2: MOSI changes only while SCLK is low, so it is stable at every rising SCLK edge where the slave samples it. Bits go most significant first.
- R3: At least 2 SPI clock periods (2*CLK_DIV system cycles) pass between chip-select falling and the first rising SCLK edge of the frame.
- R4: Chip-select stays high for at least 2 SPI clock periods between consecutive frames.
- R5: A start request sends eight frames in this order: 0x434E, 0x5953, then six frames of 0xFFFF. With SWAP_BYTES=1 (the default), the two bytes of every transmitted half-word are exchanged, so the first two frames appear on the wire as 0x4E43 and 0x5953 becomes 0x5359.
- R6: After the eighth sync frame, the block waits for `host_irq_ni` to go low. It then runs exactly two readback frames. In each one MOSI carries 0xFFFF, and MISO is captured on the rising SCLK edge, most significant bit first.
- R7: If the first readback word is 0xDCBA and the second is 0xABCD, `done_o` is set. Otherwise `err_o` is set. At most one of the three flags is ever high.
- R8: If `host_irq_ni` has not gone low within `timeout_limit_i` system cycles after the last sync frame, `timeout_o` is set, the block returns to idle and no readback frame is sent.
- R9: An accepted start request clears all three flags in the next cycle. Nothing else clears them, and a push request leaves them unchanged.
- R10: An accepted push request sends exactly one frame carrying `push_data_i`, byte-swapped when SWAP_BYTES=1 (0x1234 appears on the wire as 0x3412).
- R11: A start or push request made while `busy_o` is high is ignored.
- R12: `busy_o` goes high in the cycle after a request is accepted and stays high until the sequence ends. Chip-select is high whenever `busy_o` is low.
- R13: After reset, `cs_no` is high, `sclk_o` is low, and `busy_o`, `done_o`, `err_o` and `timeout_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse to run the sync sequence |
| push_i | input | 1 | Pulse to send one half-word |
| push_data_i | input | 16 | Half-word for a push request |
| timeout_limit_i | input | TO_W | Cycles to wait for the interrupt after the sync frames |
| busy_o | output | 1 | A sequence or push is in progress |
| done_o | output | 1 | Sticky: acknowledgement words matched |
| err_o | output | 1 | Sticky: acknowledgement mismatch |
| timeout_o | output | 1 | Sticky: interrupt never fell |
| sclk_o | output | 1 | SPI clock, idles low |
| cs_no | output | 1 | SPI chip-select, active low |
| mosi_o | output | 1 | Master data out |
| miso_i | input | 1 | Slave data in |
| host_irq_ni | input | 1 | Slave host interrupt, active low |

## Verification
A frame engine stuck in the wrong phase or counting bits incorrectly shows up within one frame, as a chip-select window that does not hold exactly 16 SCLK rises or a setup or idle gap that is too short. A sequencer index or swap fault shows up as a wrong word in the first frames of the sync sequence. A mistake in the interrupt wait or the comparison only appears at the end of the sequence, as the wrong sticky flag or a wrong number of readback frames. So each scenario checks the captured word log and the flags once `busy_o` falls.

// File: rtl/spi_sync_pkg.sv
package spi_sync_pkg;
  localparam int HW_W     = 16;
  localparam int SYNC_LEN = 8;
  localparam int ACK_LEN  = 2;
  localparam int IDX_W    = $clog2(SYNC_LEN);

  typedef logic [HW_W-1:0]  hw_t;
  typedef logic [IDX_W-1:0] idx_t;

  localparam hw_t FILL_WORD = 16'hFFFF;

  typedef enum logic [1:0] {MD_SYNC, MD_READ, MD_PUSH} mode_e;

  function automatic hw_t sync_word(input idx_t i);
    case (i)
      idx_t'(0): return 16'h434E;
      idx_t'(1): return 16'h5953;
      default:   return FILL_WORD;
    endcase
  endfunction

  function automatic hw_t ack_word(input idx_t i);
    return (i == idx_t'(0)) ? 16'hDCBA : 16'hABCD;
  endfunction

  function automatic hw_t byte_swap(input hw_t w);
    return {w[7:0], w[15:8]};
  endfunction
endpackage

// File: rtl/spi_hw_frame.sv
module spi_hw_frame
  import spi_sync_pkg::*;
#(
  parameter int CLK_DIV   = 4,
  parameter int SETUP_PER = 2,
  parameter int GAP_PER   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  hw_t  data_i,
  output logic done_o,
  output hw_t  rx_o,
  output logic sclk_o,
  output logic cs_no,
  output logic mosi_o,
  input  logic miso_i
);
  localparam int HALF      = CLK_DIV / 2;
  localparam int SETUP_CYC = SETUP_PER * CLK_DIV;
  localparam int GAP_CYC   = GAP_PER * CLK_DIV;
  localparam int CNT_MAX   = (SETUP_CYC > GAP_CYC) ? SETUP_CYC : GAP_CYC;
  localparam int CW        = $clog2(CNT_MAX + 1);
  localparam int PW        = $clog2(CLK_DIV);
  localparam int BW        = $clog2(HW_W);

  typedef enum logic [1:0] {F_IDLE, F_SETUP, F_SHIFT, F_GAP} fst_e;

  fst_e            st_q;
  logic [CW-1:0]   cnt_q;
  logic [PW-1:0]   ph_q;
  logic [BW-1:0]   bit_q;
  hw_t             tx_q, rx_q;
  logic            sclk_q, cs_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= F_IDLE;
      cnt_q  <= '0;
      ph_q   <= '0;
      bit_q  <= '0;
      tx_q   <= '1;
      rx_q   <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        F_IDLE: if (go_i) begin
          cs_q  <= 1'b0;
          tx_q  <= data_i;
          cnt_q <= CW'(SETUP_CYC - 1);
          st_q  <= F_SETUP;
        end
        F_SETUP: begin
          if (cnt_q == '0) begin
            ph_q  <= '0;
            bit_q <= '0;
            st_q  <= F_SHIFT;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        F_SHIFT: begin
          ph_q <= ph_q + 1'b1;
          // rising edge: slave samples MOSI, master captures MISO
          if (ph_q == PW'(HALF - 1)) begin
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[HW_W-2:0], miso_i};
          end
          // falling edge: advance MOSI
          if (ph_q == PW'(CLK_DIV - 1)) begin
            sclk_q <= 1'b0;
            ph_q   <= '0;
            if (bit_q == BW'(HW_W - 1)) begin
              cs_q  <= 1'b1;
              cnt_q <= CW'(GAP_CYC - 1);
              st_q  <= F_GAP;
            end else begin
              tx_q  <= {tx_q[HW_W-2:0], 1'b1};
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        F_GAP: begin
          if (cnt_q == '0) begin
            st_q   <= F_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= F_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sclk_o = sclk_q;
  assign cs_no  = cs_q;
  assign mosi_o = tx_q[HW_W-1];
endmodule

// File: rtl/spi_sync_seq.sv
module spi_sync_seq
  import spi_sync_pkg::*;
#(
  parameter bit SWAP_BYTES = 1'b1,
  parameter int TO_W       = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            push_i,
  input  hw_t             push_data_i,
  input  logic [TO_W-1:0] timeout_limit_i,
  input  logic            irq_ni,
  output logic            frm_go_o,
  output hw_t             frm_data_o,
  input  logic            frm_done_i,
  input  hw_t             frm_rx_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic            timeout_o
);
  typedef enum logic [1:0] {Q_IDLE, Q_SEND, Q_WAITF, Q_IRQ} qst_e;

  qst_e            st_q;
  mode_e           md_q;
  idx_t            idx_q;
  logic [TO_W-1:0] to_q;
  hw_t             push_q;
  logic            miss_q;
  logic [1:0]      irq_q;
  logic            done_q, err_q, to_flag_q;
  hw_t             raw_word;
  logic            mism;

  always_comb begin
    unique case (md_q)
      MD_SYNC: raw_word = sync_word(idx_q);
      MD_PUSH: raw_word = push_q;
      default: raw_word = FILL_WORD;
    endcase
  end

  generate
    if (SWAP_BYTES) begin : g_swap
      assign frm_data_o = byte_swap(raw_word);
    end else begin : g_noswap
      assign frm_data_o = raw_word;
    end
  endgenerate

  assign mism = (frm_rx_i != ack_word(idx_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= Q_IDLE;
      md_q      <= MD_SYNC;
      idx_q     <= '0;
      to_q      <= '0;
      push_q    <= '0;
      miss_q    <= 1'b0;
      irq_q     <= 2'b11;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      to_flag_q <= 1'b0;
    end else begin
      irq_q <= {irq_q[0], irq_ni};
      unique case (st_q)
        Q_IDLE: begin
          if (start_i) begin
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            to_flag_q <= 1'b0;
            miss_q    <= 1'b0;
            md_q      <= MD_SYNC;
            idx_q     <= '0;
            st_q      <= Q_SEND;
          end else if (push_i) begin
            push_q <= push_data_i;
            md_q   <= MD_PUSH;
            st_q   <= Q_SEND;
          end
        end
        Q_SEND: st_q <= Q_WAITF;
        Q_WAITF: if (frm_done_i) begin
          unique case (md_q)
            MD_SYNC: begin
              if (idx_q == idx_t'(SYNC_LEN - 1)) begin
                to_q <= '0;
                st_q <= Q_IRQ;
              end else begin
                idx_q <= idx_q + 1'b1;
                st_q  <= Q_SEND;
              end
            end
            MD_READ: begin
              if (idx_q == idx_t'(ACK_LEN - 1)) begin
                if (miss_q || mism) err_q  <= 1'b1;
                else                done_q <= 1'b1;
                st_q <= Q_IDLE;
              end else begin
                miss_q <= mism;
                idx_q  <= idx_q + 1'b1;
                st_q   <= Q_SEND;
              end
            end
            default: st_q <= Q_IDLE;
          endcase
        end
        Q_IRQ: begin
          if (!irq_q[1]) begin
            md_q  <= MD_READ;
            idx_q <= '0;
            st_q  <= Q_SEND;
          end else if (to_q == timeout_limit_i) begin
            to_flag_q <= 1'b1;
            st_q      <= Q_IDLE;
          end else begin
            to_q <= to_q + 1'b1;
          end
        end
        default: st_q <= Q_IDLE;
      endcase
    end
  end

  assign frm_go_o  = (st_q == Q_SEND);
  assign busy_o    = (st_q != Q_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign timeout_o = to_flag_q;
endmodule

// File: rtl/spi_sync_host.sv
module spi_sync_host
  import spi_sync_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int SETUP_PER  = 2,
  parameter int GAP_PER    = 2,
  parameter bit SWAP_BYTES = 1'b1,
  parameter int TO_W       = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            push_i,
  input  logic [15:0]     push_data_i,
  input  logic [TO_W-1:0] timeout_limit_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic            timeout_o,
  output logic            sclk_o,
  output logic            cs_no,
  output logic            mosi_o,
  input  logic            miso_i,
  input  logic            host_irq_ni
);
  logic frm_go, frm_done;
  hw_t  frm_data, frm_rx;

  spi_sync_seq #(
    .SWAP_BYTES (SWAP_BYTES),
    .TO_W       (TO_W)
  ) u_seq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .start_i         (start_i),
    .push_i          (push_i),
    .push_data_i     (push_data_i),
    .timeout_limit_i (timeout_limit_i),
    .irq_ni          (host_irq_ni),
    .frm_go_o        (frm_go),
    .frm_data_o      (frm_data),
    .frm_done_i      (frm_done),
    .frm_rx_i        (frm_rx),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .err_o           (err_o),
    .timeout_o       (timeout_o)
  );

  spi_hw_frame #(
    .CLK_DIV   (CLK_DIV),
    .SETUP_PER (SETUP_PER),
    .GAP_PER   (GAP_PER)
  ) u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (frm_go),
    .data_i (frm_data),
    .done_o (frm_done),
    .rx_o   (frm_rx),
    .sclk_o (sclk_o),
    .cs_no  (cs_no),
    .mosi_o (mosi_o),
    .miso_i (miso_i)
  );
endmodule

// File: rtl/spi_sync_host_chk.sv
module spi_sync_host_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic err_o,
  input logic timeout_o,
  input logic sclk_o,
  input logic cs_no,
  input logic mosi_o
);
  p_sclk_low_outside_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  p_mosi_stable_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  p_one_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({done_o, err_o, timeout_o}) <= 1);

  p_timeout_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> !busy_o);

  p_clear_on_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (!done_o && !err_o && !timeout_o));

  p_flags_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable({done_o, err_o, timeout_o}));

  p_cs_high_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);
endmodule

bind spi_sync_host spi_sync_host_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .timeout_o (timeout_o),
  .sclk_o    (sclk_o),
  .cs_no     (cs_no),
  .mosi_o    (mosi_o)
);

// File: tb/spi_sync_host_bench.sv
module spi_sync_host_bench;
  localparam int CLK_P = 10;
  localparam int DIV   = 4;
  localparam int MIN_GAP = 2 * DIV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, push = 1'b0;
  logic [15:0] push_data = '0;
  logic [15:0] to_limit = 16'd200;
  logic        busy, done, err, tmo, sclk, cs_n, mosi;
  logic        miso = 1'b0;
  logic        irq_n = 1'b1;

  always #(CLK_P/2) clk = ~clk;

  spi_sync_host u_spi_sync_host (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .push_i (push),
    .push_data_i (push_data), .timeout_limit_i (to_limit),
    .busy_o (busy), .done_o (done), .err_o (err), .timeout_o (tmo),
    .sclk_o (sclk), .cs_no (cs_n), .mosi_o (mosi), .miso_i (miso),
    .host_irq_ni (irq_n)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, frames = 0, rises = 0, t_fall = 0, t_rise = 0;
  int setup_bad = 0, gap_bad = 0, count_bad = 0, mosi_bad = 0;
  int irq_delay = -1, irq_cnt = 0;
  bit irq_counting = 0, any_frame = 0;
  logic [15:0] log_w [0:15];
  logic [15:0] cur_w = '0, rsh = '0, resp0 = '0, resp1 = '0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b1;

  // slave model and wire monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (prev_cs && !cs_n) begin
      if (any_frame && (cyc - t_rise) < MIN_GAP) gap_bad++;
      t_fall = cyc; rises = 0; cur_w = '0;
      rsh  = (frames == 8) ? resp0 : (frames == 9) ? resp1 : 16'h0000;
      miso = rsh[15];
    end
    if (sclk && cs_n) count_bad++;
    if (!cs_n && sclk && !prev_sclk) begin
      if (rises == 0 && (cyc - t_fall) < MIN_GAP) setup_bad++;
      cur_w = {cur_w[14:0], mosi};
      rises++;
    end
    if (prev_sclk && !sclk) begin
      rsh  = {rsh[14:0], 1'b0};
      miso = rsh[15];
    end
    if (prev_sclk && sclk && (mosi != prev_mosi)) mosi_bad++;
    if (!prev_cs && cs_n) begin
      if (rises != 16) count_bad++;
      if (frames < 16) log_w[frames] = cur_w;
      frames++; t_rise = cyc; any_frame = 1;
      if (frames == 8 && irq_delay >= 0) begin irq_counting = 1; irq_cnt = 0; end
    end
    if (irq_counting) begin
      if (irq_cnt >= irq_delay) begin irq_n = 1'b0; irq_counting = 0; end
      else irq_cnt++;
    end
    prev_cs = cs_n; prev_sclk = sclk; prev_mosi = mosi;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    frames = 0; setup_bad = 0; gap_bad = 0; count_bad = 0; mosi_bad = 0;
    irq_n = 1'b1; irq_counting = 0;
    for (int i = 0; i < 16; i++) log_w[i] = 16'hxxxx;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 50000) begin @(negedge clk); n++; end
    if (busy) chk(1'b0, "watchdog busy", 32'(busy), 32'd0);
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1, "R12 busy after start", 32'(busy), 32'd1);
    chk({done, err, tmo} == 3'b000, "R9 flags cleared by start", 32'({done, err, tmo}), 32'd0);
  endtask

  task automatic chk_wire(input string tag);
    chk(count_bad == 0, {"R1 frame edge count ", tag}, 32'(count_bad), 32'd0);
    chk(mosi_bad == 0,  {"R2 mosi stable ", tag},     32'(mosi_bad), 32'd0);
    chk(setup_bad == 0, {"R3 cs setup ", tag},        32'(setup_bad), 32'd0);
    chk(gap_bad == 0,   {"R4 cs gap ", tag},          32'(gap_bad), 32'd0);
  endtask

  task automatic t_reset();
    chk(cs_n == 1'b1 && sclk == 1'b0, "R13 bus idle", 32'({cs_n, sclk}), 32'h2);
    chk({busy, done, err, tmo} == 4'b0, "R13 status low", 32'({busy, done, err, tmo}), 32'd0);
  endtask

  task automatic t_sync_ok();
    clear_mon(); resp0 = 16'hDCBA; resp1 = 16'hABCD; irq_delay = 30;
    pulse_start();
    @(negedge clk) push = 1'b1; push_data = 16'h5A5A;   // R11: ignored while busy
    @(negedge clk) push = 1'b0;
    wait_idle();
    chk(frames == 10, "R6 R11 frame count", 32'(frames), 32'd10);
    chk(log_w[0] == 16'h4E43, "R5 word0", 32'(log_w[0]), 32'h4E43);
    chk(log_w[1] == 16'h5359, "R5 word1", 32'(log_w[1]), 32'h5359);
    for (int i = 2; i < 8; i++)
      chk(log_w[i] == 16'hFFFF, "R5 fill word", 32'(log_w[i]), 32'hFFFF);
    chk(log_w[8] == 16'hFFFF && log_w[9] == 16'hFFFF, "R6 readback mosi",
        32'({log_w[8], log_w[9]}), 32'hFFFFFFFF);
    chk({done, err, tmo} == 3'b100, "R7 match sets done", 32'({done, err, tmo}), 32'h4);
    chk_wire("sync");
  endtask

  task automatic t_sync_bad();
    clear_mon(); resp0 = 16'hDCBA; resp1 = 16'h1234; irq_delay = 10;
    pulse_start();
    wait_idle();
    chk(frames == 10, "R6 frame count", 32'(frames), 32'd10);
    chk({done, err, tmo} == 3'b010, "R7 mismatch sets err", 32'({done, err, tmo}), 32'h2);
    clear_mon(); resp0 = 16'h0BAD; resp1 = 16'hABCD; irq_delay = 10;
    pulse_start();
    wait_idle();
    chk({done, err, tmo} == 3'b010, "R7 first word mismatch", 32'({done, err, tmo}), 32'h2);
  endtask

  task automatic t_timeout();
    clear_mon(); irq_delay = -1;
    pulse_start();
    wait_idle();
    chk(frames == 8, "R8 no readback frame", 32'(frames), 32'd8);
    chk({done, err, tmo} == 3'b001, "R8 timeout flag", 32'({done, err, tmo}), 32'h1);
    chk(busy == 1'b0, "R8 back to idle", 32'(busy), 32'd0);
  endtask

  task automatic t_push();
    clear_mon();
    @(negedge clk) push = 1'b1; push_data = 16'h1234;
    @(negedge clk) push = 1'b0;
    chk(busy == 1'b1, "R12 busy after push", 32'(busy), 32'd1);
    wait_idle();
    chk(frames == 1, "R10 one frame", 32'(frames), 32'd1);
    chk(log_w[0] == 16'h3412, "R10 swapped push word", 32'(log_w[0]), 32'h3412);
    chk({done, err, tmo} == 3'b001, "R9 push keeps flags", 32'({done, err, tmo}), 32'h1);
    chk_wire("push");
  endtask

  task automatic t_restart();
    clear_mon(); resp0 = 16'hDCBA; resp1 = 16'hABCD; irq_delay = 5;
    pulse_start();
    wait_idle();
    chk({done, err, tmo} == 3'b100, "R9 start replaces timeout", 32'({done, err, tmo}), 32'h4);
  endtask

  initial begin
    #(CLK_P * 200000);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_sync_ok();
    t_sync_bad();
    t_timeout();
    t_push();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule